// File: doc/BRIEF.md
# Per-Bank Refresh Scheduler

This block decides when each bank of one DRAM channel gets a single-bank refresh, so that refresh of one bank overlaps with normal traffic to the others. A shared period timer adds one owed refresh to every bank at the end of each refresh period. The period length follows a two-bit temperature range input. Any bank that owes a refresh, is precharged and is not already refreshing may be offered to the row command arbiter. The banks are served in whatever order they become available, not in a fixed sequence.

The offer uses a valid/ready pair. `rf_valid` with `rf_bank` is the offer. `rf_ready` from the arbiter accepts it in the same cycle. The offer is recomputed each cycle from the current bank state, so it may move to another bank or drop while `rf_ready` is low. No refresh is committed without a handshake. Owed refreshes are kept per bank and saturate. When a bank falls too far behind, its urgent line asks the controller to force a precharge of that bank. If a bank reaches the saturation limit, the error flag is raised.

Top module: `bank_refresh_sched`

## Requirements
- R1: During and right after reset, `rf_valid`, `bank_busy`, `pre_urgent` and `owe_err` are all zero, the owed counts are zero and the period timer starts from zero.
- R2: Every bank owes one more refresh at the end of each period. The period is 2*BASE_CYC cycles for range 2'b00 (cool), BASE_CYC for 2'b01 (normal), BASE_CYC/2 for 2'b10 (extended) and BASE_CYC/4 for 2'b11 (emergency). After reset with no grants, `rf_valid` first rises after exactly one period of clock edges.
- R3: `rf_valid` is high only for a bank that owes at least one refresh, has `bank_open` low and is not busy. Within a priority class, `rf_bank` names the lowest-numbered eligible bank.
- R4: A handshake (`rf_valid` and `rf_ready` both high at a clock edge) lowers that bank's owed count by one. It also holds `bank_busy` for that bank high for exactly REF_CYC cycles after the edge.
- R5: `pre_urgent[b]` is high while bank b owes at least URG_LVL refreshes. Eligible urgent banks are offered before eligible non-urgent banks.
- R6: A bank's owed count saturates at MAX_OWED, and further period ends do not raise it. `owe_err` is high while any bank is at MAX_OWED.
- R7: While `rf_ready` is low, no owed count decreases, and the offer for an eligible bank stays raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| temp_rng | input | 2 | Temperature range: 00 cool, 01 normal, 10 extended, 11 emergency |
| bank_open | input | NBANK | High for each bank that currently has a row open |
| rf_ready | input | 1 | Arbiter accepts the offered refresh this cycle |
| rf_valid | output | 1 | A refresh is offered |
| rf_bank | output | $clog2(NBANK) | Bank targeted by the offered refresh |
| bank_busy | output | NBANK | Bank is within its refresh time |
| pre_urgent | output | NBANK | Request to force a precharge of the bank |
| owe_err | output | 1 | Some bank reached the owed-refresh limit |

## Verification
The hardest condition to reach is a bank that is due but not urgent sitting beside urgent banks that are eligible, while the other banks are blocked. Only that mix shows the urgent class winning over a lower index. The bench lets two periods pass without grants so that all banks become urgent. It refreshes bank 0 once and waits out its busy time. It then opens banks so that only bank 0 (non-urgent) and bank 3 (urgent) are eligible. Saturation is shown by letting five periods pass and then draining a single bank one handshake at a time. The number of accepted handshakes must equal the limit.

// File: rtl/rfsb_pkg.sv
package rfsb_pkg;
  typedef enum logic [1:0] {
    TR_COOL = 2'b00,
    TR_NORM = 2'b01,
    TR_EXT  = 2'b10,
    TR_EMRG = 2'b11
  } temp_e;
endpackage

// File: rtl/rfsb_timer.sv
module rfsb_timer #(
  parameter int BASE_CYC = 16,
  localparam int TW = $clog2(2 * BASE_CYC + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] temp_rng,
  output logic       tick
);
  import rfsb_pkg::*;

  logic [TW-1:0] cnt;
  logic [TW-1:0] per;

  always_comb begin
    case (temp_e'(temp_rng))
      TR_COOL: per = TW'(2 * BASE_CYC);
      TR_NORM: per = TW'(BASE_CYC);
      TR_EXT:  per = TW'(BASE_CYC / 2);
      default: per = TW'(BASE_CYC / 4);
    endcase
  end

  // >= lets a drop to a shorter period take effect at once
  assign tick = (cnt >= per - TW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + TW'(1);
  end

  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/rfsb_bank.sv
module rfsb_bank #(
  parameter int MAX_OWED = 3,
  parameter int URG_LVL  = 2,
  parameter int REF_CYC  = 3,
  localparam int OW = $clog2(MAX_OWED + 1),
  localparam int CW = $clog2(REF_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic grant,
  output logic due,
  output logic urgent,
  output logic busy,
  output logic full
);
  logic [OW-1:0] owed;
  logic [CW-1:0] bcnt;
  logic          inc;

  assign inc    = tick && (owed != OW'(MAX_OWED));
  assign due    = (owed != '0);
  assign urgent = (owed >= OW'(URG_LVL));
  assign full   = (owed == OW'(MAX_OWED));
  assign busy   = (bcnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owed <= '0;
      bcnt <= '0;
    end else begin
      case ({inc, grant})
        2'b10:   owed <= owed + OW'(1);
        2'b01:   owed <= owed - OW'(1);
        default: owed <= owed;
      endcase
      if (grant)     bcnt <= CW'(REF_CYC);
      else if (busy) bcnt <= bcnt - CW'(1);
    end
  end

  p_owed_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= OW'(MAX_OWED));
  p_grant_needs_due_r4: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> due && !busy);
  p_busy_after_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> busy);
endmodule

// File: rtl/rfsb_pick.sv
module rfsb_pick #(
  parameter int NBANK = 8,
  localparam int BW = $clog2(NBANK)
) (
  input  logic [NBANK-1:0] due,
  input  logic [NBANK-1:0] urg,
  input  logic [NBANK-1:0] open_b,
  input  logic [NBANK-1:0] busy,
  output logic             req,
  output logic [BW-1:0]    sel
);
  logic [NBANK-1:0] elig;
  logic [NBANK-1:0] hot;
  logic [NBANK-1:0] cand;

  assign elig = due & ~open_b & ~busy;
  assign hot  = elig & urg;
  assign cand = (|hot) ? hot : elig;
  assign req  = |elig;

  always_comb begin
    sel = '0;
    for (int b = NBANK - 1; b >= 0; b--) begin
      if (cand[b]) sel = BW'(b);
    end
  end

  always_comb begin
    if (req) begin
      p_pick_closed_r3: assert (elig[sel]);
      p_urgent_first_r5: assert (!(|hot) || urg[sel]);
    end
  end
endmodule

// File: rtl/bank_refresh_sched.sv
module bank_refresh_sched #(
  parameter int NBANK    = 8,
  parameter int BASE_CYC = 16,
  parameter int REF_CYC  = 3,
  parameter int MAX_OWED = 3,
  parameter int URG_LVL  = 2,
  localparam int BW = $clog2(NBANK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       temp_rng,
  input  logic [NBANK-1:0] bank_open,
  input  logic             rf_ready,
  output logic             rf_valid,
  output logic [BW-1:0]    rf_bank,
  output logic [NBANK-1:0] bank_busy,
  output logic [NBANK-1:0] pre_urgent,
  output logic             owe_err
);
  logic             tick;
  logic [NBANK-1:0] due;
  logic [NBANK-1:0] full;
  logic             fire;

  assign fire = rf_valid && rf_ready;

  rfsb_timer #(.BASE_CYC(BASE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .temp_rng(temp_rng), .tick(tick)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    rfsb_bank #(
      .MAX_OWED(MAX_OWED), .URG_LVL(URG_LVL), .REF_CYC(REF_CYC)
    ) u_bank (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .grant(fire && (rf_bank == BW'(b))),
      .due(due[b]), .urgent(pre_urgent[b]), .busy(bank_busy[b]), .full(full[b])
    );
  end

  rfsb_pick #(.NBANK(NBANK)) u_pick (
    .due(due), .urg(pre_urgent), .open_b(bank_open), .busy(bank_busy),
    .req(rf_valid), .sel(rf_bank)
  );

  assign owe_err = |full;

  p_offer_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rf_valid |-> !bank_open[rf_bank] && !bank_busy[rf_bank]);
  p_hold_offer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rf_valid && !rf_ready && !tick && $stable(bank_open) |=> rf_valid);
endmodule

// File: tb/bank_refresh_sched_tb.sv
`timescale 1ns/1ps
module bank_refresh_sched_tb;
  localparam int NB = 4, BASE = 16, RC = 3, MX = 3, UL = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    temp_rng = 2'b01;
  logic [NB-1:0] bank_open = '0;
  logic          rf_ready = 1'b0;
  logic          rf_valid;
  logic [1:0]    rf_bank;
  logic [NB-1:0] bank_busy, pre_urgent;
  logic          owe_err;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  bank_refresh_sched #(
    .NBANK(NB), .BASE_CYC(BASE), .REF_CYC(RC), .MAX_OWED(MX), .URG_LVL(UL)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .temp_rng(temp_rng), .bank_open(bank_open),
    .rf_ready(rf_ready), .rf_valid(rf_valid), .rf_bank(rf_bank),
    .bank_busy(bank_busy), .pre_urgent(pre_urgent), .owe_err(owe_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic restart(input logic [1:0] t);
    temp_rng = t; bank_open = '0; rf_ready = 1'b0; rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int per_of(input int t);
    case (t)
      0: return 2 * BASE;
      1: return BASE;
      2: return BASE / 2;
      default: return BASE / 4;
    endcase
  endfunction

  initial begin
    // R1 reset state
    restart(2'b01);
    chk(rf_valid == 0, "R1 valid", rf_valid, 0);
    chk(bank_busy == 0 && pre_urgent == 0, "R1 busy/urgent", {bank_busy, pre_urgent}, 0);
    chk(owe_err == 0, "R1 err", owe_err, 0);

    // R2 period per temperature range, all four
    for (int t = 0; t < 4; t++) begin
      int k;
      restart(t[1:0]);
      k = 0;
      while (!rf_valid && k < 200) begin
        @(posedge clk); @(negedge clk); k++;
      end
      chk(k == per_of(t), "R2 period", k, per_of(t));
      chk(rf_bank == 0, "R3 lowest bank", rf_bank, 0);
    end

    // R7 hold without ready, R3 open skip, R4 grant order and busy length
    restart(2'b01);
    edges(BASE);
    edges(2);
    chk(rf_valid == 1 && rf_bank == 0, "R7 offer held", rf_bank, 0);
    bank_open = 4'b0001; #1;
    chk(rf_bank == 1, "R3 open bank skipped", rf_bank, 1);
    bank_open = 4'b0000;
    for (int i = 0; i < NB; i++) begin
      rf_ready = 1'b1; #1;
      chk(rf_valid == 1 && rf_bank == i[1:0], "R4 grant order", rf_bank, i);
      edges(1);
    end
    rf_ready = 1'b0;
    chk(rf_valid == 0, "R4 owed cleared", rf_valid, 0);
    chk(bank_busy == 4'b1110, "R4 busy window", bank_busy, 4'b1110);
    edges(1);
    chk(bank_busy == 4'b1100, "R4 busy ends", bank_busy, 4'b1100);

    // R5 urgent priority
    restart(2'b01);
    edges(2 * BASE);
    chk(pre_urgent == 4'b1111, "R5 urgent all", pre_urgent, 4'b1111);
    chk(owe_err == 0, "R6 no err at two", owe_err, 0);
    rf_ready = 1'b1; #1;
    chk(rf_bank == 0, "R5 first grant", rf_bank, 0);
    edges(1);
    rf_ready = 1'b0;
    edges(RC);
    bank_open = 4'b0110; #1;
    chk(rf_bank == 3, "R5 urgent before lower index", rf_bank, 3);
    chk(pre_urgent == 4'b1110, "R5 urgent after grant", pre_urgent, 4'b1110);
    bank_open = 4'b1110; #1;
    chk(rf_valid == 1 && rf_bank == 0, "R5 non-urgent served", rf_bank, 0);
    bank_open = 4'b0000;
    edges(3 * BASE - (2 * BASE + 1 + RC) - 1);
    chk(owe_err == 0, "R6 err before limit", owe_err, 0);
    edges(1);
    chk(owe_err == 1, "R6 err at limit", owe_err, 1);

    // R6 saturation: five periods, drain bank 0
    restart(2'b00);
    edges(5 * 2 * BASE);
    chk(owe_err == 1, "R6 err saturated", owe_err, 1);
    bank_open = 4'b1110;
    begin
      int n;
      n = 0;
      #1;
      while (rf_valid && n < 8) begin
        rf_ready = 1'b1;
        edges(1);
        rf_ready = 1'b0;
        edges(RC);
        n++;
      end
      chk(n == MX, "R6 owed saturates", n, MX);
    end
    bank_open = 4'b0000; #1;
    chk(rf_bank == 1, "R3 next bank", rf_bank, 1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule